// File: doc/BRIEF.md
# Page-Bounded Burst Chunk Planner

This block sits beside the sequencer for repeated string operations (block move, compare, store, scan, load, port input and port output). For each repeat iteration the sequencer presents the physical source and destination addresses, the element size, the walking direction, the number of elements still to process and a few attributes of the operation and its memory. On a start strobe the planner decides whether the next stretch can be handed to a fast burst engine. It also reports how many elements that burst may cover without leaving the current 4096-byte page, and whether the instruction must be re-entered afterwards.

The result is registered and presented one cycle after the strobe, with `plan_valid` high for exactly that cycle. All result outputs then hold until the next strobe. The block does not move data and does not translate addresses. The FSM has two states. ST_IDLE waits for a strobe. ST_REPORT marks the cycle in which a fresh plan is presented. The transition ST_IDLE->ST_REPORT and the transition ST_REPORT->ST_REPORT are taken on `start`. The transition ST_REPORT->ST_IDLE is taken when `start` is low.

Top module: `cp_chunk_planner`

## Requirements
- R1: `plan_valid` is high in the cycle after a cycle with `start` high and low otherwise. `fast_en`, `slow_sel`, `chunk_cnt` and `restart` change only on the clock edge that samples `start` high. Synchronous `rst` clears all outputs to 0.
- R2: Walking upward (`dir_down`=0), the room of an address is (4096 - page offset) / element bytes, truncated. `size_code` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. The page offset is the low 12 address bits.
- R3: Walking downward (`dir_down`=1), the room is page offset / element bytes, truncated, plus 1.
- R4: `op_class` encodings are 0 move, 1 compare, 2 store, 3 scan, 4 load, 5 port-in and 6 port-out. Move and compare use the smaller of the source and destination rooms. Store, scan and port-in use the destination room. Load and port-out use the source room. Address fields and attribute flags of a side an operation does not use have no effect.
- R5: `chunk_cnt` is the smaller of the selected room and `remaining`. It is reported even when the fast path is refused.
- R6: `fast_en` requires `rep_active`, `addr32`, a nonzero `remaining` and a nonzero `chunk_cnt`.
- R7: For every operation except move, `fast_en` also requires each used address to be a multiple of the element bytes. Move may be unaligned.
- R8: `src_mmio` on a used source, or `dst_mmio` on a used destination, refuses the fast path. The one exception is a move with `dst_fb` high, which accepts a mapped-I/O destination.
- R9: A move is refused when `dir_down`=0, source < destination and destination - source < `chunk_cnt` x element bytes. It is also refused when `dir_down`=1, source > destination and source - destination < `chunk_cnt` x element bytes.
- R10: A move is refused when the page offset of either address exceeds 4096 minus the element bytes. If no other check refused it and `remaining` > 1, `restart` is then set so that one element is handled slowly and a chunk is tried again.
- R11: When `fast_en` is set, `restart` is set exactly when `remaining` > `chunk_cnt`.
- R12: In every `plan_valid` cycle `slow_sel` is the inverse of `fast_en`. When no move re-entry applies and the fast path is refused, `restart` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Evaluate the presented operation |
| op_class | input | 3 | Operation class (see R4) |
| size_code | input | 2 | Element size code (see R2) |
| dir_down | input | 1 | 1 = addresses walk downward |
| addr32 | input | 1 | 32-bit address size in effect |
| rep_active | input | 1 | A repeat prefix is present |
| src_addr | input | 32 | Physical source address |
| dst_addr | input | 32 | Physical destination address |
| remaining | input | 32 | Elements still to process |
| src_mmio | input | 1 | Source lies in mapped I/O |
| dst_mmio | input | 1 | Destination lies in mapped I/O |
| dst_fb | input | 1 | Destination lies in the frame-buffer window |
| plan_valid | output | 1 | A fresh plan is presented this cycle |
| fast_en | output | 1 | Burst engine may run the chunk |
| slow_sel | output | 1 | Element-by-element path selected |
| chunk_cnt | output | 13 | Elements in the page-bounded chunk |
| restart | output | 1 | Instruction must be re-entered afterwards |

## Verification
The overlap veto and the page clip act in the same evaluation: the overlap distance is judged against the chunk already cut at the page end, not against the full remaining count. The bench provokes this with a forward move whose source sits 256 bytes before a page end and whose destination lies 512 bytes higher with 4096 elements remaining. A count-based distance check would refuse this move, but the clipped chunk of 256 bytes clears the 512-byte distance, so the fast path must be granted with `restart` set. A second coincidence is a new strobe in the very cycle that presents the previous plan. The behavioural model checks that both plans appear back to back, with `plan_valid` held high.

// File: rtl/cp_pkg.sv
package cp_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_STORE = 3'd2,
        OP_SCAN  = 3'd3,
        OP_LOAD  = 3'd4,
        OP_PIN   = 3'd5,
        OP_POUT  = 3'd6
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } plan_st_e;

    function automatic logic reads_src(input logic [2:0] op);
        return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD) || (op == OP_POUT);
    endfunction

    function automatic logic touches_dst(input logic [2:0] op);
        return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_STORE) ||
               (op == OP_SCAN) || (op == OP_PIN);
    endfunction

    function automatic logic [1:0] size_shift(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/cp_page_room.sv
module cp_page_room #(
    parameter int PAGE_BITS = 12,
    localparam int ROOM_W = PAGE_BITS + 1
) (
    input  logic [PAGE_BITS-1:0] offset,
    input  logic [1:0]           shift,
    input  logic                 down,
    output logic [ROOM_W-1:0]    room,
    output logic                 straddle
);
    localparam logic [ROOM_W-1:0] PAGE_BYTES = ROOM_W'(1) << PAGE_BITS;

    logic [ROOM_W-1:0] off_w;
    logic [ROOM_W-1:0] elem_bytes;

    always_comb begin
        off_w      = {1'b0, offset};
        elem_bytes = ROOM_W'(1) << shift;
        if (down)
            room = (off_w >> shift) + ROOM_W'(1);
        else
            room = (PAGE_BYTES - off_w) >> shift;
        straddle = off_w > (PAGE_BYTES - elem_bytes);
    end
endmodule

// File: rtl/cp_overlap.sv
module cp_overlap #(
    parameter int ADDR_W = 32,
    parameter int ROOM_W = 13
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [ROOM_W-1:0] chunk,
    input  logic [1:0]        shift,
    input  logic              down,
    input  logic              is_move,
    output logic              hazard
);
    localparam int BYTES_W = ROOM_W + 2;

    logic [BYTES_W-1:0] span;
    logic [ADDR_W-1:0]  gap_up;
    logic [ADDR_W-1:0]  gap_dn;

    always_comb begin
        span   = {2'b00, chunk} << shift;
        gap_up = dst - src;
        gap_dn = src - dst;
        hazard = is_move &&
                 ((!down && (src < dst) && (gap_up < ADDR_W'(span))) ||
                  ( down && (src > dst) && (gap_dn < ADDR_W'(span))));
    end
endmodule

// File: rtl/cp_chunk_planner.sv
module cp_chunk_planner
    import cp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 32,
    parameter int PAGE_BITS = 12,
    localparam int ROOM_W   = PAGE_BITS + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op_class,
    input  logic [1:0]        size_code,
    input  logic              dir_down,
    input  logic              addr32,
    input  logic              rep_active,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  remaining,
    input  logic              src_mmio,
    input  logic              dst_mmio,
    input  logic              dst_fb,
    output logic              plan_valid,
    output logic              fast_en,
    output logic              slow_sel,
    output logic [ROOM_W-1:0] chunk_cnt,
    output logic              restart
);
    plan_st_e state, state_nx;

    logic [1:0]           shift;
    logic                 is_move, use_s, use_d;
    logic [PAGE_BITS-1:0] offs [2];
    logic [ROOM_W-1:0]    room [2];
    logic                 strd [2];
    logic [ROOM_W-1:0]    room_sel, chunk_nx;
    logic [ADDR_W-1:0]    amask;
    logic                 align_ok, mmio_ok, base_ok, overlap;
    logic                 pre_fast, edge_bad, fast_nx, restart_nx;

    assign offs[0] = src_addr[PAGE_BITS-1:0];
    assign offs[1] = dst_addr[PAGE_BITS-1:0];

    for (genvar g = 0; g < 2; g++) begin : g_room
        cp_page_room #(.PAGE_BITS(PAGE_BITS)) u_room (
            .offset  (offs[g]),
            .shift   (shift),
            .down    (dir_down),
            .room    (room[g]),
            .straddle(strd[g])
        );
    end

    always_comb begin
        shift   = size_shift(size_code);
        is_move = (op_class == OP_MOVE);
        use_s   = reads_src(op_class);
        use_d   = touches_dst(op_class);
        if (use_s && use_d)
            room_sel = (room[0] < room[1]) ? room[0] : room[1];
        else if (use_d)
            room_sel = room[1];
        else
            room_sel = room[0];
        chunk_nx = (remaining < CNT_W'(room_sel)) ? remaining[ROOM_W-1:0] : room_sel;
    end

    cp_overlap #(.ADDR_W(ADDR_W), .ROOM_W(ROOM_W)) u_ovl (
        .src    (src_addr),
        .dst    (dst_addr),
        .chunk  (chunk_nx),
        .shift  (shift),
        .down   (dir_down),
        .is_move(is_move),
        .hazard (overlap)
    );

    always_comb begin
        amask    = (ADDR_W'(1) << shift) - ADDR_W'(1);
        align_ok = (!use_s || ((src_addr & amask) == '0)) &&
                   (!use_d || ((dst_addr & amask) == '0));
        mmio_ok  = !(use_s && src_mmio) &&
                   !(use_d && dst_mmio && !(is_move && dst_fb));
        base_ok  = rep_active && addr32 && (remaining != '0) &&
                   (is_move || align_ok) && mmio_ok;
        pre_fast = base_ok && !overlap;
        edge_bad = is_move && (strd[0] || strd[1]);
        fast_nx  = pre_fast && !edge_bad && (chunk_nx != '0);
        if (fast_nx)
            restart_nx = remaining > CNT_W'(chunk_nx);
        else
            restart_nx = pre_fast && edge_bad && (remaining > CNT_W'(1));
    end

    // state register
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = start ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_nx = start ? ST_REPORT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            fast_en   <= 1'b0;
            slow_sel  <= 1'b0;
            chunk_cnt <= '0;
            restart   <= 1'b0;
        end else if (start) begin
            fast_en   <= fast_nx;
            slow_sel  <= !fast_nx;
            chunk_cnt <= chunk_nx;
            restart   <= restart_nx;
        end
    end

    assign plan_valid = (state == ST_REPORT);
endmodule

// File: rtl/cp_chunk_planner_chk.sv
module cp_chunk_planner_chk #(
    parameter int CNT_W  = 32,
    parameter int ROOM_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  remaining,
    input logic              rep_active,
    input logic              plan_valid,
    input logic              fast_en,
    input logic              slow_sel,
    input logic [ROOM_W-1:0] chunk_cnt,
    input logic              restart
);
    // R1
    valid_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> plan_valid);
    // R1
    valid_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!plan_valid && $stable(chunk_cnt) && $stable(fast_en) && $stable(restart)));
    // R12
    path_select_chk: assert property (@(posedge clk) disable iff (rst)
        plan_valid |-> (fast_en != slow_sel));
    // R6
    fast_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (plan_valid && fast_en) |-> ((chunk_cnt != '0) && $past(rep_active)));
    // R5
    chunk_bound_chk: assert property (@(posedge clk) disable iff (rst)
        plan_valid |-> (CNT_W'(chunk_cnt) <= $past(remaining)));
    // R11
    restart_left_chk: assert property (@(posedge clk) disable iff (rst)
        (plan_valid && fast_en) |-> (restart == ($past(remaining) > CNT_W'(chunk_cnt))));
endmodule

bind cp_chunk_planner cp_chunk_planner_chk #(.CNT_W(CNT_W), .ROOM_W(ROOM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .remaining (remaining),
    .rep_active(rep_active),
    .plan_valid(plan_valid),
    .fast_en   (fast_en),
    .slow_sel  (slow_sel),
    .chunk_cnt (chunk_cnt),
    .restart   (restart)
);

// File: tb/sim_cp_chunk_planner.sv
module sim_cp_chunk_planner;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_class = '0;
    logic [1:0]  size_code = '0;
    logic        dir_down = 1'b0, addr32 = 1'b0, rep_active = 1'b0;
    logic [31:0] src_addr = '0, dst_addr = '0, remaining = '0;
    logic        src_mmio = 1'b0, dst_mmio = 1'b0, dst_fb = 1'b0;
    logic        plan_valid, fast_en, slow_sel, restart;
    logic [12:0] chunk_cnt;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R1";

    bit          e_valid = 0, e_fast = 0, e_slow = 0, e_rst = 0;
    int unsigned e_chunk = 0;

    always #4 clk = ~clk;

    cp_chunk_planner u0 (.*);

    function automatic int unsigned room_of(input longint addr, input int bytes, input bit down);
        longint off = addr % 4096;
        if (down) return int'(off / bytes + 1);
        return int'((4096 - off) / bytes);
    endfunction

    task automatic model(output bit f, output int unsigned ch, output bit rs);
        int     bytes = (size_code == 0) ? 1 : (size_code == 1) ? 2 : 4;
        bit     mv = (op_class == 0);
        bit     us = (op_class == 0 || op_class == 1 || op_class == 4 || op_class == 6);
        bit     ud = (op_class == 0 || op_class == 1 || op_class == 2 || op_class == 3 || op_class == 5);
        int unsigned rs_room = room_of(src_addr, bytes, dir_down);
        int unsigned rd_room = room_of(dst_addr, bytes, dir_down);
        int unsigned rm;
        longint s = src_addr, d = dst_addr, span;
        bit ok, ovl, edge_hit;
        if (us && ud) rm = (rs_room < rd_room) ? rs_room : rd_room;
        else if (ud)  rm = rd_room;
        else          rm = rs_room;
        ch = (remaining < rm) ? remaining : rm;
        ok = rep_active && addr32 && remaining != 0;
        if (!mv && ((us && s % bytes != 0) || (ud && d % bytes != 0))) ok = 0;
        if (us && src_mmio) ok = 0;
        if (ud && dst_mmio && !(mv && dst_fb)) ok = 0;
        span = longint'(ch) * bytes;
        ovl = mv && ((!dir_down && s < d && d - s < span) || (dir_down && s > d && s - d < span));
        edge_hit = mv && ((s % 4096) > 4096 - bytes || (d % 4096) > 4096 - bytes);
        f  = ok && !ovl && !edge_hit && ch > 0;
        rs = f ? (remaining > ch) : (ok && !ovl && edge_hit && remaining > 1);
    endtask

    always @(posedge clk) begin
        bit f, rs; int unsigned ch;
        if (rst) begin
            e_valid = 0; e_fast = 0; e_slow = 0; e_chunk = 0; e_rst = 0;
        end else begin
            e_valid = start;
            if (start) begin
                model(f, ch, rs);
                e_fast = f; e_slow = !f; e_chunk = ch; e_rst = rs;
            end
        end
    end

    task automatic cmp1(input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) begin
        cmp1("plan_valid", plan_valid, e_valid);
        cmp1("fast_en", fast_en, e_fast);
        cmp1("slow_sel", slow_sel, e_slow);
        cmp1("chunk_cnt", chunk_cnt, e_chunk);
        cmp1("restart", restart, e_rst);
    end

    task automatic issue(input string t, input int op, input int sz, input bit dn,
                         input longint s, input longint d, input longint cnt,
                         input bit rp, input bit a32, input bit sm, input bit dm, input bit fb);
        @(negedge clk);
        tag = t;
        op_class = 3'(op); size_code = 2'(sz); dir_down = dn;
        src_addr = 32'(s); dst_addr = 32'(d); remaining = 32'(cnt);
        rep_active = rp; addr32 = a32; src_mmio = sm; dst_mmio = dm; dst_fb = fb;
        start = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    initial begin
        // R1 reset state observed by the per-clock compare
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);
        // R2 upward rooms, move takes min (R4), restart (R11)
        issue("R2", 0, 2, 0, 32'h1000_0100, 32'h2000_0200, 1000, 1, 1, 0, 0, 0); idle(1);
        issue("R2", 2, 1, 0, 0, 32'h0000_5800, 5000, 1, 1, 0, 0, 0); idle(2);
        // R3 downward rooms
        issue("R3", 4, 2, 1, 32'h0000_7010, 0, 100, 1, 1, 0, 0, 0); idle(1);
        issue("R3", 3, 0, 1, 0, 32'h0000_9000, 50, 1, 1, 0, 0, 0); idle(1);
        // R4 side selection; unused side garbage ignored
        issue("R4", 1, 1, 0, 32'h0000_1F00, 32'h0000_2100, 900, 1, 1, 0, 0, 0); idle(1);
        issue("R4", 5, 2, 0, 32'h0000_0FFF, 32'h0000_3400, 900, 1, 1, 1, 0, 0); idle(1);
        issue("R4", 6, 0, 0, 32'h0000_4E00, 32'h0000_0003, 900, 1, 1, 0, 1, 0); idle(1);
        // R5 count below room, R11 no restart
        issue("R5", 3, 0, 0, 0, 32'h0000_6000, 3, 1, 1, 0, 0, 0); idle(1);
        issue("R11", 2, 2, 0, 0, 32'h0000_6F00, 64, 1, 1, 0, 0, 0); idle(1);
        // R6 refusals
        issue("R6", 2, 0, 0, 0, 32'h0000_6000, 10, 0, 1, 0, 0, 0); idle(1);
        issue("R6", 2, 0, 0, 0, 32'h0000_6000, 10, 1, 0, 0, 0, 0); idle(1);
        issue("R6", 2, 0, 0, 0, 32'h0000_6000, 0, 1, 1, 0, 0, 0); idle(1);
        issue("R6", 2, 1, 0, 0, 32'h0000_6FFF, 10, 1, 1, 0, 0, 0); idle(1);
        // R7 alignment
        issue("R7", 2, 1, 0, 0, 32'h0000_6001, 10, 1, 1, 0, 0, 0); idle(1);
        issue("R7", 0, 2, 0, 32'h0000_1001, 32'h0008_0003, 10, 1, 1, 0, 0, 0); idle(1);
        // R8 mapped I/O
        issue("R8", 4, 0, 0, 32'h0000_1000, 0, 10, 1, 1, 1, 0, 0); idle(1);
        issue("R8", 0, 0, 0, 32'h0000_1000, 32'h0009_0000, 10, 1, 1, 0, 1, 1); idle(1);
        issue("R8", 2, 0, 0, 0, 32'h0009_0000, 10, 1, 1, 0, 1, 1); idle(1);
        issue("R8", 0, 0, 0, 32'h0000_1000, 32'h0009_0000, 10, 1, 1, 0, 1, 0); idle(1);
        // R9 overlap
        issue("R9", 0, 0, 0, 32'h0000_0100, 32'h0000_0104, 100, 1, 1, 0, 0, 0); idle(1);
        issue("R9", 0, 2, 1, 32'h0000_0200, 32'h0000_01F0, 100, 1, 1, 0, 0, 0); idle(1);
        issue("R9", 0, 0, 0, 32'h0000_0104, 32'h0000_0100, 100, 1, 1, 0, 0, 0); idle(1);
        // R9 with page clip in the same evaluation
        issue("R9", 0, 0, 0, 32'h0000_3F00, 32'h0000_4100, 4096, 1, 1, 0, 0, 0); idle(1);
        // R10 straddle, with and without re-entry
        issue("R10", 0, 2, 0, 32'h0000_1FFE, 32'h0008_0000, 10, 1, 1, 0, 0, 0); idle(1);
        issue("R10", 0, 2, 0, 32'h0000_1FFE, 32'h0008_0000, 1, 1, 1, 0, 0, 0); idle(1);
        issue("R10", 0, 1, 1, 32'h0000_1000, 32'h0008_0FFF, 10, 1, 1, 0, 0, 0); idle(1);
        // R12 refusal without re-entry keeps restart low
        issue("R12", 1, 0, 0, 32'h0000_1000, 32'h0000_2000, 10, 1, 1, 1, 0, 0); idle(1);
        // R1 back-to-back strobes, then hold
        issue("R1", 2, 0, 0, 0, 32'h0000_6000, 7, 1, 1, 0, 0, 0);
        issue("R1", 4, 2, 1, 32'h0000_5008, 0, 9, 1, 1, 0, 0, 0);
        issue("R1", 6, 1, 0, 32'h0000_5002, 0, 2000, 1, 1, 0, 0, 0); idle(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule